// File: doc/BRIEF.md
# FSK and DTMF Tone Synthesizer

This block generates the digital transmit tones for a low-speed telephone modem. It runs from a 3.579545 MHz master clock. Two phase accumulators feed a shared quarter-wave sine table, and together they produce signed sine samples. A 4-bit function-mode input picks what is sent: a frequency-shift-keyed carrier for the 300-baud or 1200-baud channels, a steady 2100 Hz answer tone, a dual-tone keypad signal, or one member of a keypad pair on its own. Every mode that cannot transmit yields silence.

The samples leave on a valid/ready stream, one candidate every `SAMPLE_DIV` master clocks. The accumulators advance on every master clock whether or not the consumer is ready, so a stalled consumer never bends the time base. A sample that has not been taken is held stable until it is accepted. Any sample produced during that wait is discarded. The next sample is loaded on the first tick at or after acceptance. Control inputs are plain levels, sampled on each clock.

Top module: `tone_synth`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `smp_valid` is low and `smp_data` is zero.
- R2: In an active mode, a sample is offered on the first active clock edge and then on every `SAMPLE_DIV`-th edge. Sample n carries the phase reached after n·`SAMPLE_DIV` clocks from the start of the active interval.
- R3: Each accumulator is 24 bits wide, wraps modulo 2^24 and adds round(f·2^24/3579545) per master clock. This keeps every tone within 1% of nominal and every FSK carrier within 6 Hz.
- R4: A single-accumulator sample is within one LSB of round(2047·sin(2π(p+0.5)/256)), where p is the top 8 phase bits.
- R5: Modes 0000 and 0001 send FSK, with `txd`=1 selecting mark. With `fsk_v21`=1 and `fsk_orig`=1 the carriers are 980/1180 Hz (mark/space). With `fsk_v21`=1 and `fsk_orig`=0 they are 1650/1850 Hz. With `fsk_v21`=0 they are 1300/2100 Hz and `fsk_orig` is ignored.
- R6: Mode 0011 sends a continuous 2100 Hz tone.
- R7: Modes 0100 and 1001 send the saturated sum of a row tone and a column tone, clamped to [-2048, 2047]. Row tones are 697 Hz for codes 1,2,3,13, 770 Hz for 4,5,6,14, 852 Hz for 7,8,9,15, and 941 Hz for 0,10,11,12. Column tones are 1209 Hz for 1,4,7,11, 1336 Hz for 2,5,8,10, 1477 Hz for 3,6,9,12, and 1633 Hz for 0,13,14,15.
- R8: Mode 0101 sends one tone from the low accumulator: the row tone of the R7 table for codes 0–7 and the column tone for codes 8–15.
- R9: A change of `txd`, tone code, FSK selection or active mode changes only the increments and never resets the phase. The high accumulator holds its phase in modes that use one tone.
- R10: In every other mode (0010, 0110, 0111, 1000, 1010–1111), `smp_valid` is low, `smp_data` is zero, and both accumulators and the tick divider are cleared. On re-entry to an active mode, the first sample has phase zero.
- R11: While `smp_valid` is high and `smp_ready` is low, `smp_data` is held. A tick that falls during the hold produces no sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| func_mode | input | 4 | Function mode code |
| tone_code | input | 4 | Keypad code for dual and single tone modes |
| txd | input | 1 | FSK data bit, 1 = mark |
| fsk_v21 | input | 1 | 1 = 300-baud channel pair, 0 = 1200-baud carrier |
| fsk_orig | input | 1 | 300-baud channel: 1 = originate, 0 = answer |
| smp_ready | input | 1 | Consumer accepts the offered sample |
| smp_valid | output | 1 | A sample is offered |
| smp_data | output | 12 | Signed sample, two's complement |

## Verification
The hardest situation to reach is a divider tick that lands while an earlier sample is still held. In that case the new sample must be dropped, and the accumulators must keep running, so the next accepted sample is taken from a phase several ticks later. The bench reaches this by driving `smp_ready` from a pseudo-random sequence across a long dual-tone run, and it tracks the phase cycle by cycle. Phase continuity is the other difficult case. The bench toggles `txd` and walks the tone code at intervals that share no factor with the divider, and it moves between active modes without passing through a silent mode. As a result, every change lands at a different offset within a sample period.

// File: rtl/tone_synth_pkg.sv
`timescale 1ns/1ps
package tone_synth_pkg;
  // function mode codes
  localparam logic [3:0] FM_FSK     = 4'b0000;
  localparam logic [3:0] FM_FSK_LB  = 4'b0001;
  localparam logic [3:0] FM_ANS     = 4'b0011;
  localparam logic [3:0] FM_DUAL    = 4'b0100;
  localparam logic [3:0] FM_SINGLE  = 4'b0101;
  localparam logic [3:0] FM_DUAL_LB = 4'b1001;

  // keypad row (low group) frequency in Hz
  function automatic int row_hz(input int c);
    case (c)
      1, 2, 3, 13:   return 697;
      4, 5, 6, 14:   return 770;
      0, 10, 11, 12: return 941;
      default:       return 852;
    endcase
  endfunction

  // keypad column (high group) frequency in Hz
  function automatic int col_hz(input int c);
    case (c)
      1, 4, 7, 11:  return 1209;
      2, 5, 8, 10:  return 1336;
      3, 6, 9, 12:  return 1477;
      default:      return 1633;
    endcase
  endfunction

  // rounded phase increment for a tone
  function automatic longint inc_of(input int hz, input int acc_w, input int clk_hz);
    longint num;
    num = (longint'(hz) << acc_w) + longint'(clk_hz / 2);
    return num / longint'(clk_hz);
  endfunction
endpackage

// File: rtl/tone_freq_sel.sv
`timescale 1ns/1ps
module tone_freq_sel
  import tone_synth_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int CLK_HZ = 3579545
) (
  input  logic [3:0]       mode,
  input  logic [3:0]       code,
  input  logic             txd,
  input  logic             v21,
  input  logic             orig,
  output logic             active,
  output logic             dual,
  output logic [ACC_W-1:0] inc_lo,
  output logic [ACC_W-1:0] inc_hi
);
  localparam int NCODE = 16;

  function automatic logic [ACC_W-1:0] incw(input int hz);
    longint n;
    n = inc_of(hz, ACC_W, CLK_HZ);
    return n[ACC_W-1:0];
  endfunction

  function automatic logic [NCODE*ACC_W-1:0] build_tab(input bit high);
    logic [NCODE*ACC_W-1:0] t;
    t = '0;
    for (int c = 0; c < NCODE; c++)
      t[c*ACC_W +: ACC_W] = incw(high ? col_hz(c) : row_hz(c));
    return t;
  endfunction

  localparam logic [NCODE*ACC_W-1:0] ROW_TAB = build_tab(1'b0);
  localparam logic [NCODE*ACC_W-1:0] COL_TAB = build_tab(1'b1);
  localparam logic [ACC_W-1:0] I_OM = incw(980);
  localparam logic [ACC_W-1:0] I_OS = incw(1180);
  localparam logic [ACC_W-1:0] I_AM = incw(1650);
  localparam logic [ACC_W-1:0] I_AS = incw(1850);
  localparam logic [ACC_W-1:0] I_FM = incw(1300);
  localparam logic [ACC_W-1:0] I_2K1 = incw(2100);

  logic [ACC_W-1:0] row_inc, col_inc, fsk_inc;

  always_comb begin
    row_inc = ROW_TAB[code*ACC_W +: ACC_W];
    col_inc = COL_TAB[code*ACC_W +: ACC_W];
    if (v21) begin
      if (orig) fsk_inc = txd ? I_OM : I_OS;
      else      fsk_inc = txd ? I_AM : I_AS;
    end else begin
      fsk_inc = txd ? I_FM : I_2K1;
    end
  end

  always_comb begin
    active = 1'b0;
    dual   = 1'b0;
    inc_lo = '0;
    inc_hi = '0;
    case (mode)
      FM_FSK, FM_FSK_LB: begin
        active = 1'b1;
        inc_lo = fsk_inc;
      end
      FM_ANS: begin
        active = 1'b1;
        inc_lo = I_2K1;
      end
      FM_DUAL, FM_DUAL_LB: begin
        active = 1'b1;
        dual   = 1'b1;
        inc_lo = row_inc;
        inc_hi = col_inc;
      end
      FM_SINGLE: begin
        active = 1'b1;
        inc_lo = code[3] ? col_inc : row_inc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tone_phase_acc.sv
`timescale 1ns/1ps
module tone_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else          phase <= phase + inc;
  end
endmodule

// File: rtl/tone_sine_rom.sv
`timescale 1ns/1ps
module tone_sine_rom #(
  parameter int SMP_W  = 12,
  parameter int TBL_AW = 8
) (
  input  logic [TBL_AW-1:0]       ph,
  output logic signed [SMP_W-1:0] smp
);
  localparam int QA    = TBL_AW - 2;
  localparam int QN    = 2 ** QA;
  localparam int MAG_W = SMP_W - 1;
  localparam longint AMP   = (longint'(1) << MAG_W) - 1;
  localparam longint PI_FX = 64'd3373259426; // pi scaled by 2^30

  // quarter wave at half-step offsets, Taylor series in 2^30 fixed point
  function automatic logic [QN*MAG_W-1:0] build_qtab();
    logic [QN*MAG_W-1:0] t;
    longint x, term, s, v;
    t = '0;
    for (int i = 0; i < QN; i++) begin
      x    = (longint'(2 * i + 1) * PI_FX) >>> (QA + 2);
      term = x;
      s    = x;
      for (int k = 1; k <= 5; k++) begin
        term = (term * x) >>> 30;
        term = (term * x) >>> 30;
        term = -term / longint'((2 * k) * (2 * k + 1));
        s    = s + term;
      end
      v = (s * AMP + (longint'(1) <<< 29)) >>> 30;
      t[i*MAG_W +: MAG_W] = v[MAG_W-1:0];
    end
    return t;
  endfunction

  localparam logic [QN*MAG_W-1:0] QTAB = build_qtab();

  logic [QA-1:0]    idx;
  logic [MAG_W-1:0] mag;
  logic signed [SMP_W-1:0] pos;

  always_comb begin
    idx = ph[TBL_AW-2] ? ~ph[QA-1:0] : ph[QA-1:0];
    mag = QTAB[idx*MAG_W +: MAG_W];
    pos = $signed({1'b0, mag});
    smp = ph[TBL_AW-1] ? -pos : pos;
  end
endmodule

// File: rtl/tone_synth.sv
`timescale 1ns/1ps
module tone_synth #(
  parameter int ACC_W      = 24,
  parameter int CLK_HZ     = 3579545,
  parameter int SMP_W      = 12,
  parameter int TBL_AW     = 8,
  parameter int SAMPLE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       func_mode,
  input  logic [3:0]       tone_code,
  input  logic             txd,
  input  logic             fsk_v21,
  input  logic             fsk_orig,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [SMP_W-1:0] smp_data
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int NACC  = 2;
  localparam logic signed [SMP_W:0] S_MAX = (SMP_W+1)'((1 << (SMP_W-1)) - 1);
  localparam logic signed [SMP_W:0] S_MIN = -(SMP_W+1)'(1 << (SMP_W-1));

  logic                    active, dual;
  logic [ACC_W-1:0]        inc   [NACC];
  logic [ACC_W-1:0]        phase [NACC];
  logic signed [SMP_W-1:0] tone  [NACC];
  logic [DIV_W-1:0]        div_q;
  logic                    tick;
  logic signed [SMP_W:0]   sum_w;
  logic signed [SMP_W-1:0] mix;

  tone_freq_sel #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) sel_i (
    .mode(func_mode), .code(tone_code), .txd(txd), .v21(fsk_v21), .orig(fsk_orig),
    .active(active), .dual(dual), .inc_lo(inc[0]), .inc_hi(inc[1])
  );

  for (genvar g = 0; g < NACC; g++) begin : g_tone
    tone_phase_acc #(.ACC_W(ACC_W)) acc_i (
      .clk(clk), .rst_n(rst_n), .clr(!active), .inc(inc[g]), .phase(phase[g])
    );
    tone_sine_rom #(.SMP_W(SMP_W), .TBL_AW(TBL_AW)) rom_i (
      .ph(phase[g][ACC_W-1 -: TBL_AW]), .smp(tone[g])
    );
  end

  // sample-rate divider, restarted whenever output is silent
  always_ff @(posedge clk) begin
    if (!rst_n || !active)                        div_q <= '0;
    else if (div_q == DIV_W'(SAMPLE_DIV - 1))     div_q <= '0;
    else                                          div_q <= div_q + 1'b1;
  end
  assign tick = active && (div_q == '0);

  // saturated mix of the two tones
  always_comb begin
    sum_w = {tone[0][SMP_W-1], tone[0]} + {tone[1][SMP_W-1], tone[1]};
    if (!dual)             mix = tone[0];
    else if (sum_w > S_MAX) mix = S_MAX[SMP_W-1:0];
    else if (sum_w < S_MIN) mix = S_MIN[SMP_W-1:0];
    else                    mix = sum_w[SMP_W-1:0];
  end

  // output stage: hold until accepted, drop ticks during a hold
  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else if (tick && (!smp_valid || smp_ready)) begin
      smp_valid <= 1'b1;
      smp_data  <= mix;
    end else if (smp_valid && smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && active) |=> (smp_valid && $stable(smp_data)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!smp_valid && smp_data == '0));

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(tick));

  // R4
  sine_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0][ACC_W-1] ? (tone[0] < 0) : (tone[0] > 0));

  if (SAMPLE_DIV > 1) begin : g_gap
    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

// File: tb/tone_synth_tb_top.sv
`timescale 1ns/1ps
module tone_synth_tb_top;
  localparam int     DIV  = 8;
  localparam longint MASK = (longint'(1) << 24) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_i = 4'b0010;
  logic [3:0] code_i = 4'b0000;
  logic       txd_i = 1'b1, v21_i = 1'b1, orig_i = 1'b1, ready_i = 1'b1;
  logic       smp_valid;
  logic [11:0] smp_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_tag = "R2";
  bit rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  longint mA = 0, mB = 0;
  int mdiv = 0, mdata = 0, mtol = 1;
  bit mvalid = 1'b0, m_idle = 1'b1;

  always #10 clk = ~clk;

  tone_synth dut_i (
    .clk(clk), .rst_n(rst_n), .func_mode(mode_i), .tone_code(code_i), .txd(txd_i),
    .fsk_v21(v21_i), .fsk_orig(orig_i), .smp_ready(ready_i),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint b_inc(input int hz);
    return ((longint'(hz) << 24) + 64'd1789772) / 64'd3579545;
  endfunction

  function automatic int b_row(input int c);
    if (c inside {1, 2, 3, 13}) return 697;
    if (c inside {4, 5, 6, 14}) return 770;
    if (c inside {7, 8, 9, 15}) return 852;
    return 941;
  endfunction

  function automatic int b_col(input int c);
    if (c inside {1, 4, 7, 11}) return 1209;
    if (c inside {2, 5, 8, 10}) return 1336;
    if (c inside {3, 6, 9, 12}) return 1477;
    return 1633;
  endfunction

  function automatic int b_sin(input longint ph);
    int p;
    real v;
    p = int'((ph >> 16) & 255);
    v = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic b_sel(output bit act, output bit dl, output longint ia, output longint ib);
    int c;
    c = int'(code_i);
    act = 1'b1; dl = 1'b0; ia = 0; ib = 0;
    case (mode_i)
      4'b0000, 4'b0001:
        if (v21_i) ia = orig_i ? b_inc(txd_i ? 980 : 1180) : b_inc(txd_i ? 1650 : 1850);
        else       ia = b_inc(txd_i ? 1300 : 2100);
      4'b0011: ia = b_inc(2100);
      4'b0100, 4'b1001: begin dl = 1'b1; ia = b_inc(b_row(c)); ib = b_inc(b_col(c)); end
      4'b0101: ia = (c >= 8) ? b_inc(b_col(c)) : b_inc(b_row(c));
      default: act = 1'b0;
    endcase
  endtask

  task automatic model_edge();
    bit act, dl;
    longint ia, ib;
    int s;
    b_sel(act, dl, ia, ib);
    s = b_sin(mA);
    if (dl) begin
      s = s + b_sin(mB);
      if (s > 2047) s = 2047;
      if (s < -2048) s = -2048;
    end
    if (!act) begin
      mA = 0; mB = 0; mdiv = 0; mvalid = 1'b0; mdata = 0; m_idle = 1'b1;
    end else begin
      m_idle = 1'b0;
      if (mdiv == 0 && (!mvalid || ready_i)) begin
        mvalid = 1'b1; mdata = s; mtol = dl ? 2 : 1;
      end else if (mvalid && ready_i) mvalid = 1'b0;
      mA = (mA + ia) & MASK;
      mB = (mB + ib) & MASK;
      mdiv = (mdiv == DIV - 1) ? 0 : mdiv + 1;
    end
  endtask

  task automatic compare();
    int diff;
    chk(smp_valid === mvalid, m_idle ? "R10" : "R2", int'(smp_valid), int'(mvalid));
    if (m_idle)
      chk(smp_data === 12'd0, "R10", int'($signed(smp_data)), 0);
    else if (mvalid) begin
      diff = int'($signed(smp_data)) - mdata;
      chk(diff <= mtol && diff >= -mtol, cur_tag, int'($signed(smp_data)), mdata);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    if (rdy_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready_i = lfsr[0] & lfsr[5];
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [3:0] c, input int n, input string tag);
    mode_i = 4'b0010;
    cur_tag = "R10";
    repeat (2) cyc();
    mode_i = m;
    code_i = c;
    cur_tag = tag;
    repeat (n) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(smp_valid === 1'b0, "R1", int'(smp_valid), 0);
    chk(smp_data === 12'd0, "R1", int'(smp_data), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(smp_valid === 1'b0 && smp_data === 12'd0, "R1", int'(smp_valid), 0);

    // R10: every silent mode
    for (int m = 0; m < 16; m++) begin
      if (!(m inside {0, 1, 3, 4, 5, 9})) begin
        mode_i = 4'(m); code_i = 4'(m);
        repeat (30) cyc();
      end
    end

    // R5: all carrier selections
    for (int v = 0; v < 2; v++)
      for (int o = 0; o < 2; o++)
        for (int t = 0; t < 2; t++) begin
          v21_i = v[0]; orig_i = o[0]; txd_i = t[0];
          run(4'b0000, 4'd0, 200, "R5");
        end
    v21_i = 1'b1; orig_i = 1'b0; txd_i = 1'b0;
    run(4'b0001, 4'd3, 200, "R5");

    // R6 and R3 (long run wraps the accumulator)
    run(4'b0011, 4'd0, 200, "R6");
    run(4'b0011, 4'd7, 2200, "R3");
    // R4: exact table shape from phase zero
    run(4'b0101, 4'd0, 300, "R4");

    // R7: all keypad codes
    for (int c = 0; c < 16; c++) run(4'b0100, 4'(c), 200, "R7");
    run(4'b1001, 4'd13, 200, "R7");
    run(4'b1001, 4'd6, 200, "R7");

    // R8: all single tone codes
    for (int c = 0; c < 16; c++) run(4'b0101, 4'(c), 200, "R8");

    // R9: data toggles and code walks without any phase reset
    v21_i = 1'b0;
    run(4'b0000, 4'd0, 5, "R9");
    for (int i = 0; i < 50; i++) begin txd_i = ~txd_i; repeat (13) cyc(); end
    v21_i = 1'b1; orig_i = 1'b1;
    for (int i = 0; i < 20; i++) begin txd_i = ~txd_i; orig_i = i[2]; repeat (11) cyc(); end
    mode_i = 4'b0101;
    for (int i = 0; i < 16; i++) begin code_i = 4'(i); repeat (29) cyc(); end
    mode_i = 4'b0100; repeat (90) cyc();
    mode_i = 4'b0101; code_i = 4'd9; repeat (53) cyc();
    mode_i = 4'b1001; code_i = 4'd2; repeat (77) cyc();
    mode_i = 4'b0011; repeat (41) cyc();

    // R11: random back-pressure on a dual tone
    rdy_rand = 1'b1;
    run(4'b0100, 4'd5, 1500, "R11");
    run(4'b0000, 4'd0, 600, "R11");
    rdy_rand = 1'b0; ready_i = 1'b1;
    run(4'b0101, 4'd12, 100, "R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule